// File: doc/BRIEF.md
# Register Alias Table Renamer

This block is the rename stage of a small out-of-order core. It has one row per architectural register. Each row records whether an in-flight uop will produce that register's value and, if so, the reorder-buffer tag of the newest such producer. One uop enters per cycle with two source registers, an optional destination and the ROB tag the allocator gave it. Tags are handed out in program order. For each source the block reports either "pending on ROB tag T" or "not pending, read the committed register file". It then makes the uop the newest writer of its destination.

Retirement names an architectural register and a ROB tag. The row is cleared only when that tag is still the newest writer. A flush clears every row in a single cycle and drops any result that has not been taken. Renamed results sit in a one-entry output register that is controlled by a two-state machine. In `OS_EMPTY` the register holds nothing. An accepted uop moves it to `OS_FULL`. In `OS_FULL` the register holds a result: a consumer handshake with no new uop moves it back to `OS_EMPTY`, a simultaneous new uop keeps it in `OS_FULL`, and a flush forces `OS_EMPTY` from either state.

Top module: `rat_renamer`

## Requirements
- R1: After reset no row holds a mapping, `out_valid` is 0 and `in_ready` is 1.
- R2: A source whose row holds a mapping is reported with pend=1 and the stored ROB tag.
- R3: A source whose row holds no mapping is reported with pend=0 and tag 0, meaning it reads the committed register file.
- R4: An accepted uop with `in_dst_en`=1 writes `in_tag` into its destination row. Its own sources see the mapping from before this write, so a uop such as r1 <- r1+r0 depends on the previous writer of r1.
- R5: A retire clears its row only when the row is valid and holds exactly `ret_tag`. Otherwise the retire has no effect.
- R6: When a retire and an accepted rename target the same row in one cycle, the row ends up holding the rename's tag.
- R7: A retire that clears a row in the same cycle as a lookup of that row makes that lookup report pend=0.
- R8: `flush` clears every row in one cycle, empties the output register on the next edge and holds `in_ready` at 0 while asserted, so no uop is accepted in that cycle.
- R9: `in_ready` = !flush && (!out_valid || out_ready). While `out_valid`=1 and `out_ready`=0 and there is no flush, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all mappings and drop the pending result |
| in_valid | input | 1 | Uop offered |
| in_ready | output | 1 | Uop accepted this cycle when in_valid is also 1 |
| in_src0 | input | AW | First source architectural register |
| in_src1 | input | AW | Second source architectural register |
| in_dst_en | input | 1 | Uop writes a destination register |
| in_dst | input | AW | Destination architectural register |
| in_tag | input | TAG_W | ROB tag allocated to this uop |
| ret_valid | input | 1 | A uop retires this cycle |
| ret_dst | input | AW | Destination register of the retiring uop |
| ret_tag | input | TAG_W | ROB tag of the retiring uop |
| out_valid | output | 1 | Renamed result available |
| out_ready | input | 1 | Consumer takes the result |
| out_src0_pend | output | 1 | First source waits on a ROB entry |
| out_src0_tag | output | TAG_W | ROB tag for the first source (0 if not pending) |
| out_src1_pend | output | 1 | Second source waits on a ROB entry |
| out_src1_tag | output | TAG_W | ROB tag for the second source (0 if not pending) |
| out_tag | output | TAG_W | ROB tag of the renamed uop |

## Verification
Retire and rename can touch the same row in one cycle, and so can retire and a source lookup. Directed steps provoke both. One step retires a row's current tag while a new uop writes that row. Another retires the tag that a source of the new uop depends on. Later lookups through the normal port then show whether the row holds the newer tag, or whether the source was reported as reading the committed file. The random phase draws the retire tag from the current row contents most of the time, so matching retires land on rows that are being renamed or looked up in the same cycle. Each result is compared against a bench model that applies the R4, R6 and R7 ordering.

// File: rtl/rat_pkg.sv
package rat_pkg;
    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostate_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/rat_table.sv
module rat_table #(
    parameter int NARCH = 8,
    parameter int TAG_W = 4,
    localparam int AW = $clog2(NARCH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_idx,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic                           rt_en,
    input  logic [AW-1:0]                  rt_idx,
    input  logic [TAG_W-1:0]               rt_tag,
    output logic [NARCH-1:0]               row_valid,
    output logic [NARCH-1:0][TAG_W-1:0]    row_tag
);
    for (genvar i = 0; i < NARCH; i++) begin : g_row
        logic hit_wr;
        logic hit_rt;
        assign hit_wr = wr_en && (wr_idx == AW'(i));
        assign hit_rt = rt_en && (rt_idx == AW'(i)) && (row_tag[i] == rt_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_valid[i] <= 1'b0;
                row_tag[i]   <= '0;
            end else if (flush) begin
                row_valid[i] <= 1'b0;
            end else if (hit_wr) begin
                // newer writer beats a retire of the older one
                row_valid[i] <= 1'b1;
                row_tag[i]   <= wr_tag;
            end else if (hit_rt) begin
                row_valid[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup #(
    parameter int NARCH = 8,
    parameter int TAG_W = 4,
    localparam int AW = $clog2(NARCH)
) (
    input  logic [AW-1:0]                  idx,
    input  logic [NARCH-1:0]               row_valid,
    input  logic [NARCH-1:0][TAG_W-1:0]    row_tag,
    input  logic                           rt_en,
    input  logic [AW-1:0]                  rt_idx,
    input  logic [TAG_W-1:0]               rt_tag,
    output logic                           pend,
    output logic [TAG_W-1:0]               tag
);
    logic retiring;

    always_comb begin
        retiring = rt_en && (rt_idx == idx) && (row_tag[idx] == rt_tag);
        pend     = row_valid[idx] && !retiring;
        tag      = pend ? row_tag[idx] : '0;
    end
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer #(
    parameter int NARCH = 8,
    parameter int TAG_W = 4,
    localparam int AW = $clog2(NARCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [AW-1:0]    in_src0,
    input  logic [AW-1:0]    in_src1,
    input  logic             in_dst_en,
    input  logic [AW-1:0]    in_dst,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             ret_valid,
    input  logic [AW-1:0]    ret_dst,
    input  logic [TAG_W-1:0] ret_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_src0_pend,
    output logic [TAG_W-1:0] out_src0_tag,
    output logic             out_src1_pend,
    output logic [TAG_W-1:0] out_src1_tag,
    output logic [TAG_W-1:0] out_tag
);
    import rat_pkg::*;

    ostate_e state_q, state_d;

    logic [NARCH-1:0]             row_valid;
    logic [NARCH-1:0][TAG_W-1:0]  row_tag;
    logic [NUM_SRC-1:0][AW-1:0]   src_idx;
    logic [NUM_SRC-1:0]           lk_pend;
    logic [NUM_SRC-1:0][TAG_W-1:0] lk_tag;
    logic [NUM_SRC-1:0]           pend_q;
    logic [NUM_SRC-1:0][TAG_W-1:0] stag_q;
    logic [TAG_W-1:0]             tag_q;
    logic                         accept;

    assign src_idx = {in_src1, in_src0};

    rat_table #(.NARCH(NARCH), .TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (accept && in_dst_en),
        .wr_idx    (in_dst),
        .wr_tag    (in_tag),
        .rt_en     (ret_valid),
        .rt_idx    (ret_dst),
        .rt_tag    (ret_tag),
        .row_valid (row_valid),
        .row_tag   (row_tag)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rat_lookup #(.NARCH(NARCH), .TAG_W(TAG_W)) u_lookup (
            .idx       (src_idx[s]),
            .row_valid (row_valid),
            .row_tag   (row_tag),
            .rt_en     (ret_valid),
            .rt_idx    (ret_dst),
            .rt_tag    (ret_tag),
            .pend      (lk_pend[s]),
            .tag       (lk_tag[s])
        );
    end

    // next-state logic
    always_comb begin
        in_ready = !flush && ((state_q == OS_EMPTY) || out_ready);
        accept   = in_valid && in_ready;
        state_d  = state_q;
        unique case (state_q)
            OS_EMPTY: if (accept) state_d = OS_FULL;
            OS_FULL:  if (out_ready && !accept) state_d = OS_EMPTY;
        endcase
        if (flush) state_d = OS_EMPTY;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            stag_q <= '0;
            tag_q  <= '0;
        end else if (accept) begin
            pend_q <= lk_pend;
            stag_q <= lk_tag;
            tag_q  <= in_tag;
        end
    end

    // outputs
    always_comb begin
        out_valid     = (state_q == OS_FULL);
        out_src0_pend = pend_q[0];
        out_src0_tag  = stag_q[0];
        out_src1_pend = pend_q[1];
        out_src1_tag  = stag_q[1];
        out_tag       = tag_q;
    end
endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_src0_pend,
    input logic [TAG_W-1:0] out_src0_tag,
    input logic             out_src1_pend,
    input logic [TAG_W-1:0] out_src1_tag,
    input logic [TAG_W-1:0] out_tag
);
    a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_tag) && $stable(out_src0_tag) &&
             $stable(out_src1_tag) && $stable(out_src0_pend) && $stable(out_src1_pend)));

    a_r3_idle_tag0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_src0_pend) |-> (out_src0_tag == '0));

    a_r3_idle_tag1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_src1_pend) |-> (out_src1_tag == '0));
endmodule

bind rat_renamer rat_renamer_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/rat_renamer_bench.sv
`timescale 1ns/1ps
module rat_renamer_bench;
    localparam int NARCH = 8;
    localparam int TAG_W = 4;
    localparam int AW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, in_valid = 1'b0, in_dst_en = 1'b0, ret_valid = 1'b0, out_ready = 1'b1;
    logic [AW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0, ret_dst = '0;
    logic [TAG_W-1:0] in_tag = '0, ret_tag = '0;
    logic in_ready, out_valid, out_src0_pend, out_src1_pend;
    logic [TAG_W-1:0] out_src0_tag, out_src1_tag, out_tag;

    always #2.5 clk = ~clk;

    rat_renamer #(.NARCH(NARCH), .TAG_W(TAG_W)) u_rat_renamer (.*);

    int total = 0, bad = 0;
    logic             mv [NARCH];
    logic [TAG_W-1:0] mt [NARCH];
    logic             e_ov = 1'b0, e_p0 = 1'b0, e_p1 = 1'b0;
    logic [TAG_W-1:0] e_t0 = '0, e_t1 = '0, e_tag = '0, nt = '0;
    string            e_lbl = "R1";

    task automatic chk(input string lbl, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    function automatic logic lk_p(input int a, input logic rv, input int rd, input logic [TAG_W-1:0] rt);
        return mv[a] && !(rv && rd == a && mt[a] == rt);
    endfunction

    task automatic step(input string lbl, input logic iv, input int s0, input int s1,
                        input logic de, input int d, input logic rv, input int rd,
                        input logic [TAG_W-1:0] rt, input logic fl, input logic ordy);
        logic er, acc, p0, p1;
        @(negedge clk);
        chk({e_lbl, " out_valid"}, {31'd0, out_valid}, {31'd0, e_ov});
        if (e_ov)
            chk({e_lbl, " fields"},
                {14'd0, out_src0_pend, out_src0_tag, out_src1_pend, out_src1_tag, out_tag},
                {14'd0, e_p0, e_t0, e_p1, e_t1, e_tag});
        in_valid = iv; in_src0 = AW'(s0); in_src1 = AW'(s1); in_dst_en = de; in_dst = AW'(d);
        in_tag = nt; ret_valid = rv; ret_dst = AW'(rd); ret_tag = rt; flush = fl; out_ready = ordy;
        #1;
        er  = !fl && (!e_ov || ordy);
        chk({lbl, " R9 in_ready"}, {31'd0, in_ready}, {31'd0, er});
        acc = iv && er;
        p0  = lk_p(s0, rv, rd, rt);
        p1  = lk_p(s1, rv, rd, rt);
        if (fl) e_ov = 1'b0;
        else if (acc) begin
            e_ov = 1'b1; e_p0 = p0; e_p1 = p1;
            e_t0 = p0 ? mt[s0] : '0; e_t1 = p1 ? mt[s1] : '0; e_tag = nt; e_lbl = lbl;
        end else if (ordy) e_ov = 1'b0;
        for (int i = 0; i < NARCH; i++) begin
            if (fl) mv[i] = 1'b0;
            else if (acc && de && d == i) begin mv[i] = 1'b1; mt[i] = nt; end
            else if (rv && rd == i && mv[i] && mt[i] == rt) mv[i] = 1'b0;
        end
        if (acc) nt = nt + 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [TAG_W-1:0] t2;
        for (int i = 0; i < NARCH; i++) begin mv[i] = 1'b0; mt[i] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
        // empty table: sources read committed file
        step("R1 R3 empty lookup", 1, 1, 2, 0, 0, 0, 0, 0, 0, 1);
        // r1 <- r1+r0 sees old (empty) mapping, then r1 is pending
        step("R4 self source", 1, 1, 0, 1, 1, 0, 0, 0, 0, 1);
        step("R2 R4 dependent", 1, 1, 1, 1, 1, 0, 0, 0, 0, 1);
        // retire of older tag for r1 is ignored
        step("R5 stale retire", 1, 0, 0, 0, 0, 1, 1, mt[1] - 1'b1, 0, 1);
        step("R5 R2 after stale", 1, 1, 3, 0, 0, 0, 0, 0, 0, 1);
        // retire matching tag in same cycle as lookup of r1
        step("R7 retire bypass", 1, 1, 1, 0, 0, 1, 1, mt[1], 0, 1);
        step("R5 cleared", 1, 1, 2, 0, 0, 0, 0, 0, 0, 1);
        // rename r2, then retire it while a newer uop writes r2
        step("R6 setup", 1, 0, 0, 1, 2, 0, 0, 0, 0, 1);
        t2 = mt[2];
        step("R6 collide", 1, 3, 3, 1, 2, 1, 2, t2, 0, 1);
        step("R6 newer wins", 1, 2, 2, 0, 0, 0, 0, 0, 0, 1);
        // stall output register
        step("R9 stall a", 1, 2, 1, 1, 5, 0, 0, 0, 0, 0);
        step("R9 stall b", 1, 5, 5, 0, 0, 0, 0, 0, 0, 0);
        step("R9 stall c", 1, 5, 2, 0, 0, 0, 0, 0, 0, 1);
        // flush with a uop offered and a result waiting
        step("R8 pre", 1, 0, 0, 1, 6, 0, 0, 0, 0, 0);
        step("R8 flush", 1, 6, 2, 1, 7, 0, 0, 0, 1, 0);
        step("R8 after flush", 1, 6, 2, 0, 0, 0, 0, 0, 0, 1);
        step("R8 after flush 2", 1, 5, 7, 0, 0, 0, 0, 0, 0, 1);
        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int rd;
            logic [TAG_W-1:0] rt;
            rd = int'($urandom_range(NARCH - 1));
            rt = ($urandom_range(9) < 7) ? mt[rd] : TAG_W'($urandom);
            step("R2 R3 R4 R5 R6 R7 R9 random",
                 $urandom_range(9) < 8,
                 int'($urandom_range(NARCH - 1)), int'($urandom_range(NARCH - 1)),
                 $urandom_range(9) < 7, int'($urandom_range(NARCH - 1)),
                 $urandom_range(9) < 4, rd, rt,
                 $urandom_range(99) < 3, $urandom_range(3) != 0);
        end
        step("R9 drain", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R9 drain", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule